// File: doc/BRIEF.md
# Cross-Lane Permute Unit

This block sits in front of a vector ALU and moves 32-bit source values between the 64 lanes of a vector register before the operation is applied. A 9-bit control code selects the routing. It can permute freely within each group of four lanes, shift or rotate within each 16-lane row, shift or rotate the whole vector by one lane, mirror a row or half row, or broadcast one lane into later rows. Sign modifiers (absolute value, negate) act on the source data before it is routed.

Two masks gate the result. One enables whole rows and the other enables lane positions within each group of four. A bound-zero bit decides what a lane receives when its source is outside the allowed range or belongs to a disabled lane. The block registers its result once, so the routed vector and a per-lane write-enable vector appear on the cycle after the request. Codes that do not name a routing pass the lanes straight through and raise a one-cycle flag.

Top module: `xlane_permute`

## Requirements
- R1: While reset is asserted and until the first accepted request, out_valid, illegal_ctrl, lane_we and out_vec are all zero.
- R2: A request taken with in_valid high shows up on the outputs one clock later with out_valid high. While in_valid is low, out_vec and lane_we keep their values and out_valid is low.
- R3: When ctrl[8] is 0, the lane at position k (0..3) of a four-lane group reads the lane of the same group given by ctrl[2k+1:2k].
- R4: Codes 0x101..0x10F make lane i read lane i+n, and codes 0x111..0x11F make it read lane i-n, where n = ctrl[3:0]. A source outside lane i's 16-lane row is out of range.
- R5: Codes 0x121..0x12F make lane i read lane (row base + ((p - n) mod 16)), where p is i's position in its row. No source is out of range.
- R6: Code 0x130 reads lane i+1 and code 0x138 reads lane i-1, and in each case a source beyond lane 63 or below lane 0 is out of range. Code 0x134 reads lane (i+1) mod 64 and code 0x13C reads lane (i-1) mod 64.
- R7: Code 0x140 makes position p of a row read position 15-p of the same row. Code 0x141 makes position q of an 8-lane half row read position 7-q of that half row.
- R8: Code 0x142 makes every lane of rows 1..3 read the last lane of the row before it. Code 0x143 makes every lane of rows 2 and 3 read lane 31. The other rows read their own lanes.
- R9: Lane i is enabled only when row_mask[i/16] and bank_mask[i mod 4] are both 1. A disabled lane has lane_we low and carries its own (modified) source value.
- R10: For an enabled lane whose source is out of range or disabled: if bound_zero is 1, the lane outputs 0 with lane_we high. If bound_zero is 0, it outputs its own value with lane_we low.
- R11: Modifiers act on two's-complement data before routing. With src_abs set, negative values become their magnitude. With src_neg set, the value (after any absolute step) is negated, so setting both gives the negated magnitude.
- R12: Any code with ctrl[8]=1 that R4..R8 do not name works as identity routing: each enabled lane reads itself with lane_we high. It also sets illegal_ctrl high together with out_valid, for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| src_vec | input | LANES*DATA_W | Source vector, lane j at bits [j*DATA_W +: DATA_W] |
| ctrl | input | 9 | Routing control code |
| row_mask | input | LANES/ROW_LANES | Row enables |
| bank_mask | input | 4 | Lane-position enables within groups of four |
| bound_zero | input | 1 | Zero fill for invalid sources |
| src_abs | input | 1 | Absolute-value modifier |
| src_neg | input | 1 | Negate modifier |
| out_valid | output | 1 | Result valid |
| out_vec | output | LANES*DATA_W | Routed vector |
| lane_we | output | LANES | Per-lane write enable |
| illegal_ctrl | output | 1 | Unrecognised control code seen |

## Verification
The bench builds the block with its defaults: 32-bit lanes, 64 lanes and 16-lane rows. These values give four rows, so the row-to-row broadcasts, the lane-31 broadcast and every row-mask bit can be reached. They also put both edges of the whole vector and of each row in range of the shift codes. The lane values are all distinct, and in one pattern they alternate in sign. This makes every wrong source index, every missing zero fill and every wrong modifier order show up as a visible mismatch.

// File: rtl/xlane_permute.sv
module xlane_permute #(
  parameter int DATA_W    = 32,
  parameter int LANES     = 64,
  parameter int ROW_LANES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [LANES*DATA_W-1:0]   src_vec,
  input  logic [8:0]                ctrl,
  input  logic [LANES/ROW_LANES-1:0] row_mask,
  input  logic [3:0]                bank_mask,
  input  logic                      bound_zero,
  input  logic                      src_abs,
  input  logic                      src_neg,
  output logic                      out_valid,
  output logic [LANES*DATA_W-1:0]   out_vec,
  output logic [LANES-1:0]          lane_we,
  output logic                      illegal_ctrl
);
  localparam int IW = $clog2(LANES);

  function automatic logic [DATA_W-1:0] modify(input logic [DATA_W-1:0] x,
                                               input logic a, input logic n);
    logic [DATA_W-1:0] y;
    y = (a && x[DATA_W-1]) ? -x : x;
    return n ? -y : y;
  endfunction

  function automatic logic known(input logic [8:0] c);
    if (!c[8]) return 1'b1;
    if (c[7:4] <= 4'h2) return c[3:0] != 4'h0;
    case (c[7:0])
      8'h30, 8'h34, 8'h38, 8'h3C, 8'h40, 8'h41, 8'h42, 8'h43: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // returns {out_of_range, source_index}
  function automatic logic [IW:0] route(input int i, input logic [8:0] c);
    int p, b, n, s;
    logic bad;
    p = i % ROW_LANES;
    b = i - p;
    n = int'(c[3:0]);
    s = i;
    bad = 1'b0;
    if (!c[8]) s = (i & ~3) + int'(c[2*(i%4) +: 2]);
    else if (c[7:4] == 4'h0 && n != 0) begin s = i + n; bad = (p + n > ROW_LANES - 1); end
    else if (c[7:4] == 4'h1 && n != 0) begin s = i - n; bad = (p < n); end
    else if (c[7:4] == 4'h2 && n != 0) s = b + ((p - n + ROW_LANES) % ROW_LANES);
    else begin
      case (c[7:0])
        8'h30: begin s = i + 1; bad = (i == LANES - 1); end
        8'h34: s = (i + 1) % LANES;
        8'h38: begin s = i - 1; bad = (i == 0); end
        8'h3C: s = (i + LANES - 1) % LANES;
        8'h40: s = b + ROW_LANES - 1 - p;
        8'h41: s = (i & ~7) + 7 - (i % 8);
        8'h42: if (b != 0) s = b - 1;
        8'h43: if (b >= 2 * ROW_LANES) s = 2 * ROW_LANES - 1;
        default: s = i;
      endcase
    end
    if (bad) s = i;
    return {bad, IW'(s)};
  endfunction

  logic [DATA_W-1:0]       mod_d [LANES];
  logic [LANES-1:0]        en, nxt_we;
  logic [LANES*DATA_W-1:0] nxt_vec;

  for (genvar j = 0; j < LANES; j++) begin : g_src
    assign mod_d[j] = modify(src_vec[j*DATA_W +: DATA_W], src_abs, src_neg);
    assign en[j]    = row_mask[j/ROW_LANES] & bank_mask[j%4];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [IW:0] rt;
    logic        ok;
    assign rt = route(i, ctrl);
    assign ok = !rt[IW] && en[rt[IW-1:0]];
    assign nxt_vec[i*DATA_W +: DATA_W] = !en[i]     ? mod_d[i] :
                                         ok         ? mod_d[rt[IW-1:0]] :
                                         bound_zero ? '0 : mod_d[i];
    assign nxt_we[i] = en[i] & (ok | bound_zero);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      illegal_ctrl <= 1'b0;
      out_vec      <= '0;
      lane_we      <= '0;
    end else begin
      out_valid    <= in_valid;
      illegal_ctrl <= in_valid & ~known(ctrl);
      if (in_valid) begin
        out_vec <= nxt_vec;
        lane_we <= nxt_we;
      end
    end
  end
endmodule

// File: rtl/xlane_permute_chk.sv
module xlane_permute_chk #(
  parameter int DATA_W    = 32,
  parameter int LANES     = 64,
  parameter int ROW_LANES = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic [LANES/ROW_LANES-1:0] row_mask,
  input logic [3:0]                 bank_mask,
  input logic                       out_valid,
  input logic [LANES*DATA_W-1:0]    out_vec,
  input logic [LANES-1:0]           lane_we,
  input logic                       illegal_ctrl
);
  logic [LANES-1:0] en_mask;
  for (genvar j = 0; j < LANES; j++) begin : g_en
    assign en_mask[j] = row_mask[j/ROW_LANES] & bank_mask[j%4];
  end

  p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_vec) && $stable(lane_we) && !out_valid));
  p_we_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((lane_we & ~$past(en_mask)) == '0));
  p_illegal_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_ctrl |-> out_valid);
  p_illegal_we_r12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_ctrl |-> (lane_we == $past(en_mask)));
endmodule

bind xlane_permute xlane_permute_chk #(
  .DATA_W(DATA_W), .LANES(LANES), .ROW_LANES(ROW_LANES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .row_mask(row_mask),
  .bank_mask(bank_mask), .out_valid(out_valid), .out_vec(out_vec),
  .lane_we(lane_we), .illegal_ctrl(illegal_ctrl)
);

// File: tb/xlane_permute_tb_top.sv
module xlane_permute_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int L  = 64;
  localparam int RL = 16;
  localparam int NR = L / RL;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [L*W-1:0] src_vec, out_vec;
  logic [8:0]     ctrl = '0;
  logic [NR-1:0]  row_mask = '0;
  logic [3:0]     bank_mask = '0;
  logic bound_zero = 1'b0, src_abs = 1'b0, src_neg = 1'b0;
  logic out_valid, illegal_ctrl;
  logic [L-1:0] lane_we;
  logic [W-1:0] lane_val [L];

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int j = 0; j < L; j++) src_vec[j*W +: W] = lane_val[j];

  xlane_permute #(.DATA_W(W), .LANES(L), .ROW_LANES(RL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .ctrl(ctrl), .row_mask(row_mask), .bank_mask(bank_mask),
    .bound_zero(bound_zero), .src_abs(src_abs), .src_neg(src_neg),
    .out_valid(out_valid), .out_vec(out_vec), .lane_we(lane_we),
    .illegal_ctrl(illegal_ctrl));

  task automatic check(input bit ok, input string msg);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic fill(input int kind);
    for (int j = 0; j < L; j++)
      lane_val[j] = (kind == 0) ? W'(32'h100 + j) :
                    ((j % 2) ? W'(-(j + 1)) : W'(j + 1));
  endtask

  function automatic bit legal_code(input int c);
    if (c < 256) return 1;
    if ((c > 256 && c < 272) || (c > 272 && c < 288) || (c > 288 && c < 304)) return 1;
    return (c == 304 || c == 308 || c == 312 || c == 316 || (c >= 320 && c <= 323));
  endfunction

  function automatic void model(input int i, input int c, output int s, output bit bad);
    int row, p, n;
    row = i / RL; p = i % RL; n = c % 16; s = i; bad = 0;
    if (!legal_code(c)) s = i;
    else if (c < 256) s = 4 * (i / 4) + ((c >> (2 * (i % 4))) & 3);
    else if (c < 272) begin if (p + n < RL) s = i + n; else bad = 1; end
    else if (c < 288) begin if (p >= n) s = i - n; else bad = 1; end
    else if (c < 304) s = row * RL + (p + RL - n) % RL;
    else if (c == 304) begin if (i < L - 1) s = i + 1; else bad = 1; end
    else if (c == 308) s = (i == L - 1) ? 0 : i + 1;
    else if (c == 312) begin if (i > 0) s = i - 1; else bad = 1; end
    else if (c == 316) s = (i == 0) ? L - 1 : i - 1;
    else if (c == 320) s = row * RL + (RL - 1 - p);
    else if (c == 321) s = 8 * (i / 8) + (7 - i % 8);
    else if (c == 322) s = (row > 0) ? row * RL - 1 : i;
    else s = (row >= 2) ? 31 : i;
  endfunction

  function automatic logic [W-1:0] mval(input int j, input bit a, input bit n);
    longint v;
    v = longint'($signed(lane_val[j]));
    if (a && v < 0) v = -v;
    if (n) v = -v;
    return W'(v);
  endfunction

  task automatic run(input int c, input logic [NR-1:0] rm, input logic [3:0] bm,
                     input bit bz, input bit a, input bit n, input string tag);
    logic [W-1:0] ed;
    bit ew, de, se, bad;
    int s, bad_lane;
    @(negedge clk);
    ctrl = 9'(c); row_mask = rm; bank_mask = bm;
    bound_zero = bz; src_abs = a; src_neg = n; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    bad_lane = -1;
    for (int i = 0; i < L; i++) begin
      model(i, c, s, bad);
      de = rm[i / RL] && bm[i % 4];
      se = rm[s / RL] && bm[s % 4];
      if (!de) begin ed = mval(i, a, n); ew = 0; end
      else if (bad || !se) begin ed = bz ? '0 : mval(i, a, n); ew = bz; end
      else begin ed = mval(s, a, n); ew = 1; end
      if (bad_lane < 0 && (out_vec[i*W +: W] !== ed || lane_we[i] !== ew)) begin
        bad_lane = i;
        $display("FAIL %s ctrl=%h lane %0d: got %h/we%b exp %h/we%b",
                 tag, c, i, out_vec[i*W +: W], lane_we[i], ed, ew);
      end
    end
    n_run++;
    if (bad_lane >= 0) n_fail++;
    check(out_valid === 1'b1 && illegal_ctrl === !legal_code(c),
          $sformatf("%s ctrl=%h flags: valid=%b illegal=%b exp 1/%b",
                    tag, c, out_valid, illegal_ctrl, !legal_code(c)));
  endtask

  task automatic t_reset();
    check(out_valid === 0 && illegal_ctrl === 0 && lane_we === '0 && out_vec === '0,
          $sformatf("R1 reset: valid=%b illegal=%b we=%h exp 0", out_valid, illegal_ctrl, lane_we));
  endtask

  task automatic t_hold();
    logic [L*W-1:0] v;
    logic [L-1:0] we;
    v = out_vec; we = lane_we;
    fill(1);
    @(negedge clk); @(negedge clk);
    check(out_valid === 0 && out_vec === v && lane_we === we,
          $sformatf("R2 hold: valid=%b changed=%b exp 0/0", out_valid, (out_vec !== v) || (lane_we !== we)));
    fill(0);
  endtask

  task automatic t_pulse();
    run(9'h150, 4'hF, 4'hF, 1, 0, 0, "R12 reserved");
    @(negedge clk);
    check(illegal_ctrl === 0, $sformatf("R12 pulse: illegal=%b exp 0", illegal_ctrl));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    fill(0);
    #(CLK_PERIOD * 2);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    run(9'h01B, 4'hF, 4'hF, 0, 0, 0, "R3 quad reverse");
    run(9'h000, 4'hF, 4'hF, 0, 0, 0, "R3 quad bcast");
    run(9'h0E4, 4'hF, 4'hF, 0, 0, 0, "R3 quad identity");
    t_hold();
    run(9'h103, 4'hF, 4'hF, 1, 0, 0, "R4 row shl zero");
    run(9'h10F, 4'hF, 4'hF, 0, 0, 0, "R4 R10 row shl keep");
    run(9'h115, 4'hF, 4'hF, 1, 0, 0, "R4 row shr");
    run(9'h124, 4'hF, 4'hF, 0, 0, 0, "R5 row ror");
    run(9'h12F, 4'hF, 4'hF, 0, 0, 0, "R5 row ror 15");
    run(9'h130, 4'hF, 4'hF, 1, 0, 0, "R6 wf shl");
    run(9'h134, 4'hF, 4'hF, 0, 0, 0, "R6 wf rol");
    run(9'h138, 4'hF, 4'hF, 0, 0, 0, "R6 wf shr");
    run(9'h13C, 4'hF, 4'hF, 0, 0, 0, "R6 wf ror");
    run(9'h140, 4'hF, 4'hF, 0, 0, 0, "R7 mirror");
    run(9'h141, 4'hF, 4'hF, 0, 0, 0, "R7 half mirror");
    run(9'h142, 4'hF, 4'hF, 0, 0, 0, "R8 bcast row");
    run(9'h143, 4'hF, 4'hF, 0, 0, 0, "R8 bcast 31");
    run(9'h0E4, 4'b0101, 4'b1011, 0, 0, 0, "R9 masked identity");
    run(9'h140, 4'b0110, 4'b0011, 1, 0, 0, "R9 R10 mirror src off zero");
    run(9'h140, 4'b0110, 4'b0011, 0, 0, 0, "R10 mirror src off keep");
    run(9'h142, 4'b1110, 4'hF, 1, 0, 0, "R10 bcast from off row");
    fill(1);
    run(9'h0E4, 4'hF, 4'hF, 0, 1, 0, "R11 abs");
    run(9'h0E4, 4'hF, 4'hF, 0, 0, 1, "R11 neg");
    run(9'h124, 4'hF, 4'hF, 0, 1, 1, "R11 abs then neg");
    fill(0);
    run(9'h100, 4'hF, 4'hF, 1, 0, 0, "R12 reserved 100");
    run(9'h131, 4'hF, 4'b0101, 1, 0, 0, "R12 reserved 131");
    run(9'h1FF, 4'hF, 4'hF, 0, 0, 0, "R12 reserved 1FF");
    t_pulse();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule